// File: doc/BRIEF.md
# SDRAM Self-Refresh and Power-Down Sequencer

This block sits on the controller side of a DDR SDRAM and decides, every clock, which command the memory sees and where its clock-enable stands. Software requests self-refresh by raising two control bits while the controller-enable bit stays set. The block then wakes the clock-enable if needed, issues the self-refresh command with CKE low, and reports entry on a status bit. Clearing both bits brings the memory back out. A recovery lockout then holds off non-read commands for one count of cycles and reads for a longer count.

Outside self-refresh the block serves three sources: a software command field for precharge-all and auto-refresh, a periodic refresh tick, and bus-side access requests that get a grant pulse in the cycle their command goes out. A separate clock-enable level puts the idle memory into power-down. In that mode each access costs one extra clock to raise CKE before the command, and CKE drops again on the clock after it.

Top module: `sdram_lp_seq`

## Requirements
- R1: During and right after reset the command bus is deselect (`{cs_n,ras_n,cas_n,we_n}` = 1111), CKE is low, and the status bit and grant are low.
- R2: When `ctrl_en_i`, `sr_arm_i` and `sr_req_i` are all 1 and the block is idle with CKE high, the next edge drives the self-refresh command (0001) with CKE low in the same cycle. If CKE is low at that point, one wake cycle with CKE high and deselect comes first. With `ctrl_en_i` at 0 no entry happens.
- R3: The status bit rises one edge after CKE falls on entry and falls one edge after CKE rises on exit. While it is high the bus stays deselect and no grant is given.
- R4: Self-refresh is left only when `sr_arm_i` and `sr_req_i` are both 0. The edge that sees this raises CKE. Clearing just one of the two keeps the memory in self-refresh.
- R5: After the exit edge, precharge-all (0010), auto-refresh (0001 with CKE high) and write (0100) are not driven until more than `T_NRD` edges after the edge that raised CKE. A waiting command issues on the first allowed edge.
- R6: After the exit edge, read (0101) is not driven until more than `T_RD` edges after the edge that raised CKE.
- R7: `sw_cmd_i` = 01 queues a precharge-all and 10 queues an auto-refresh. Other values do nothing. The code is captured only in the idle state and issues one edge later. Back-to-back codes issue on consecutive edges with no spacing added.
- R8: Periodic refresh runs only after a 0-to-1 change of `arf_run_i` seen in the idle state. It stops on self-refresh entry and whenever `arf_run_i` is 0. While running, a tick issues an auto-refresh two edges after the tick is sampled.
- R9: Ticks are dropped while self-refresh is in progress, while the non-read lockout is active, or while periodic refresh is stopped. Access requests are held off in self-refresh.
- R10: When idle with no work, CKE follows `cke_keep_i` one edge later (0 = power-down).
- R11: In power-down an access is granted two edges after it is first sampled, not one. CKE falls on the edge after the command.
- R12: `acc_gnt_o` pulses exactly in the cycle that carries the access's read or write command. Priority, highest first: self-refresh entry, software command, periodic refresh, access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_en_i | input | 1 | Controller enabled; must be 1 for self-refresh entry |
| sr_arm_i | input | 1 | Self-refresh arm bit |
| sr_req_i | input | 1 | Self-refresh mode bit |
| cke_keep_i | input | 1 | Idle clock-enable level; 0 selects power-down |
| sw_cmd_i | input | 2 | Software command: 01 precharge-all, 10 auto-refresh |
| arf_run_i | input | 1 | Periodic refresh enable; a rising change restarts it |
| arf_tick_i | input | 1 | Periodic refresh interval tick |
| acc_req_i | input | 1 | Access request, held until granted |
| acc_wr_i | input | 1 | Access is a write (1) or read (0) |
| cs_n_o | output | 1 | Chip select, active low |
| ras_n_o | output | 1 | Row strobe, active low |
| cas_n_o | output | 1 | Column strobe, active low |
| we_n_o | output | 1 | Write enable, active low |
| cke_o | output | 1 | Memory clock enable |
| sr_stat_o | output | 1 | Memory is in self-refresh |
| acc_gnt_o | output | 1 | Access granted; same cycle as its command |

## Verification
A wrong state or a stray transition shows within one clock as a CKE level, a command code or a status value that differs from the reference model. Every cycle is compared, so a mistake in the entry or exit path is reported on the edge where it happens. A lockout counter that is one count short or long moves the first command after exit by one cycle, and the measured gap from the CKE rise reports it. A refresh enable left set across self-refresh shows as an extra auto-refresh after the first tick once recovery is over.

// File: rtl/sdram_lp_pkg.sv
`timescale 1ns/1ps
package sdram_lp_pkg;

  // command bus value {cs_n, ras_n, cas_n, we_n}
  typedef enum logic [3:0] {
    CMD_NOP  = 4'b1111,
    CMD_PALL = 4'b0010,
    CMD_REF  = 4'b0001,
    CMD_RD   = 4'b0101,
    CMD_WR   = 4'b0100
  } cmd_e;

  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_SRIN  = 2'd1,
    S_SR    = 2'd2,
    S_SROUT = 2'd3
  } st_e;

  localparam logic [1:0] SW_PALL = 2'b01;
  localparam logic [1:0] SW_REF  = 2'b10;

  // counter width able to hold n
  function automatic int cnt_w(int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

  function automatic logic sw_valid(logic [1:0] c);
    return (c == SW_PALL) || (c == SW_REF);
  endfunction

  function automatic cmd_e sw_to_cmd(logic [1:0] c);
    return (c == SW_PALL) ? CMD_PALL : CMD_REF;
  endfunction

endpackage

// File: rtl/lp_downcnt.sv
`timescale 1ns/1ps
// Recovery lockout: loads LIMIT, counts down to zero, free when zero.
module lp_downcnt #(
  parameter int LIMIT = 7,
  parameter int W     = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load_i,
  output logic free_o
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)               cnt_q <= '0;
    else if (load_i)          cnt_q <= W'(LIMIT);
    else if (cnt_q != '0)     cnt_q <= cnt_q - W'(1);
  end

  assign free_o = (cnt_q == '0);
endmodule

// File: rtl/lp_refresh_gate.sv
`timescale 1ns/1ps
// Periodic refresh enable and pending flag.
module lp_refresh_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic run_i,
  input  logic tick_i,
  input  logic idle_i,
  input  logic open_i,
  input  logic stop_i,
  input  logic taken_i,
  output logic pend_o
);
  logic run_q, on_q, pend_q;
  logic run_rise;

  assign run_rise = run_i && !run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q  <= 1'b0;
      on_q   <= 1'b0;
      pend_q <= 1'b0;
    end else begin
      run_q <= run_i;
      if (stop_i || !run_i)        on_q <= 1'b0;
      else if (run_rise && idle_i) on_q <= 1'b1;
      if (stop_i)                                  pend_q <= 1'b0;
      else if (tick_i && on_q && idle_i && open_i) pend_q <= 1'b1;
      else if (taken_i)                            pend_q <= 1'b0;
    end
  end

  assign pend_o = pend_q;
endmodule

// File: rtl/sdram_lp_seq.sv
`timescale 1ns/1ps
module sdram_lp_seq
  import sdram_lp_pkg::*;
#(
  parameter int T_NRD = 7,
  parameter int T_RD  = 200
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ctrl_en_i,
  input  logic       sr_arm_i,
  input  logic       sr_req_i,
  input  logic       cke_keep_i,
  input  logic [1:0] sw_cmd_i,
  input  logic       arf_run_i,
  input  logic       arf_tick_i,
  input  logic       acc_req_i,
  input  logic       acc_wr_i,
  output logic       cs_n_o,
  output logic       ras_n_o,
  output logic       cas_n_o,
  output logic       we_n_o,
  output logic       cke_o,
  output logic       sr_stat_o,
  output logic       acc_gnt_o
);
  localparam int CW = cnt_w((T_RD > T_NRD) ? T_RD : T_NRD);

  st_e        st_q, st_d;
  cmd_e       cmd_q, cmd_d;
  logic       cke_q, cke_d, stat_q, gnt_q;
  logic [1:0] sw_q;
  logic [1:0] free;
  logic       rf_pend;

  // named internal events
  logic nrd_free, rd_free, idle, want_sr, leave_sr;
  logic job_sw, job_rf, job_acc, any_job, fire;
  logic sr_enter_ev, sr_exit_ev, take_sw, take_rf, take_acc;

  assign nrd_free    = free[0];
  assign rd_free     = free[1];
  assign idle        = (st_q == S_IDLE);
  assign want_sr     = ctrl_en_i && sr_arm_i && sr_req_i;
  assign leave_sr    = !sr_arm_i && !sr_req_i;
  assign job_sw      = (sw_q != 2'b00) && nrd_free;
  assign job_rf      = rf_pend && nrd_free;
  assign job_acc     = acc_req_i && (acc_wr_i ? nrd_free : rd_free);
  assign any_job     = job_sw || job_rf || job_acc;
  assign sr_enter_ev = idle && cke_q && want_sr;
  assign sr_exit_ev  = (st_q == S_SR) && leave_sr;
  assign fire        = idle && cke_q && !want_sr && any_job;
  assign take_sw     = fire && job_sw;
  assign take_rf     = fire && !job_sw && job_rf;
  assign take_acc    = fire && !job_sw && !job_rf && job_acc;

  for (genvar g = 0; g < 2; g++) begin : g_lock
    lp_downcnt #(
      .LIMIT((g == 0) ? T_NRD : T_RD),
      .W    (CW)
    ) u_cnt (
      .clk   (clk),
      .rst_n (rst_n),
      .load_i(sr_exit_ev),
      .free_o(free[g])
    );
  end

  lp_refresh_gate u_rfg (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_i  (arf_run_i),
    .tick_i (arf_tick_i),
    .idle_i (idle),
    .open_i (nrd_free),
    .stop_i (sr_enter_ev),
    .taken_i(take_rf),
    .pend_o (rf_pend)
  );

  always_comb begin
    cmd_d = CMD_NOP;
    if (sr_enter_ev)   cmd_d = CMD_REF;
    else if (take_sw)  cmd_d = sw_to_cmd(sw_q);
    else if (take_rf)  cmd_d = CMD_REF;
    else if (take_acc) cmd_d = acc_wr_i ? CMD_WR : CMD_RD;
  end

  always_comb begin
    st_d  = st_q;
    cke_d = cke_q;
    unique case (st_q)
      S_IDLE: begin
        if (want_sr || any_job) cke_d = !sr_enter_ev;
        else                    cke_d = cke_keep_i;
        if (sr_enter_ev)        st_d  = S_SRIN;
      end
      S_SRIN: begin
        cke_d = 1'b0;
        st_d  = S_SR;
      end
      S_SR: begin
        cke_d = leave_sr;
        if (leave_sr) st_d = S_SROUT;
      end
      default: begin
        cke_d = 1'b1;
        st_d  = S_IDLE;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      cmd_q  <= CMD_NOP;
      cke_q  <= 1'b0;
      stat_q <= 1'b0;
      gnt_q  <= 1'b0;
      sw_q   <= 2'b00;
    end else begin
      st_q  <= st_d;
      cmd_q <= cmd_d;
      cke_q <= cke_d;
      gnt_q <= take_acc;
      if (st_q == S_SRIN)       stat_q <= 1'b1;
      else if (st_q == S_SROUT) stat_q <= 1'b0;
      if (sr_enter_ev)                   sw_q <= 2'b00;
      else if (idle && sw_valid(sw_cmd_i)) sw_q <= sw_cmd_i;
      else if (take_sw)                  sw_q <= 2'b00;
    end
  end

  assign {cs_n_o, ras_n_o, cas_n_o, we_n_o} = cmd_q;
  assign cke_o     = cke_q;
  assign sr_stat_o = stat_q;
  assign acc_gnt_o = gnt_q;
endmodule

// File: rtl/sdram_lp_sva.sv
`timescale 1ns/1ps
module sdram_lp_sva
  import sdram_lp_pkg::*;
(
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] cmd,
  input logic       cke_o,
  input logic       sr_stat_o,
  input logic       acc_gnt_o,
  input logic       nrd_free,
  input logic       rd_free,
  input logic       sr_enter_ev,
  input logic       sr_exit_ev
);
  p_enter_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sr_enter_ev |=> (!cke_o && cmd == CMD_REF));

  p_lowcmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!cke_o && cmd != CMD_NOP) |-> (cmd == CMD_REF && $past(cke_o)));

  p_stat_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sr_stat_o) |-> (!cke_o && $past(!cke_o)));

  p_stat_clr_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sr_stat_o) |-> (cke_o && $past(cke_o)));

  p_sr_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sr_stat_o |-> (cmd == CMD_NOP && !acc_gnt_o));

  p_exit_r4: assert property (@(posedge clk) disable iff (!rst_n)
    sr_exit_ev |=> cke_o);

  p_nrd_lock_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (cke_o && (cmd == CMD_PALL || cmd == CMD_REF || cmd == CMD_WR)) |-> $past(nrd_free));

  p_rd_lock_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd == CMD_RD) |-> $past(rd_free));

  p_gnt_cmd_r12: assert property (@(posedge clk) disable iff (!rst_n)
    acc_gnt_o |-> (cmd == CMD_RD || cmd == CMD_WR));
endmodule

bind sdram_lp_seq sdram_lp_sva u_sva (
  .clk        (clk),
  .rst_n      (rst_n),
  .cmd        ({cs_n_o, ras_n_o, cas_n_o, we_n_o}),
  .cke_o      (cke_o),
  .sr_stat_o  (sr_stat_o),
  .acc_gnt_o  (acc_gnt_o),
  .nrd_free   (nrd_free),
  .rd_free    (rd_free),
  .sr_enter_ev(sr_enter_ev),
  .sr_exit_ev (sr_exit_ev)
);

// File: tb/tb_sdram_lp_seq.sv
`timescale 1ns/1ps
module tb_sdram_lp_seq;
  localparam int NRD = 7;
  localparam int RD  = 20;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ctrl_en = 1'b1, arm = 1'b0, req = 1'b0, keep = 1'b0;
  logic [1:0] sw = 2'b00;
  logic run = 1'b0, tick = 1'b0, areq = 1'b0, awr = 1'b0;
  logic cs_n, ras_n, cas_n, we_n, cke, stat, gnt;

  always #10 clk = ~clk;

  sdram_lp_seq #(.T_NRD(NRD), .T_RD(RD)) dut (
    .clk(clk), .rst_n(rst_n), .ctrl_en_i(ctrl_en), .sr_arm_i(arm), .sr_req_i(req),
    .cke_keep_i(keep), .sw_cmd_i(sw), .arf_run_i(run), .arf_tick_i(tick),
    .acc_req_i(areq), .acc_wr_i(awr), .cs_n_o(cs_n), .ras_n_o(ras_n),
    .cas_n_o(cas_n), .we_n_o(we_n), .cke_o(cke), .sr_stat_o(stat), .acc_gnt_o(gnt));

  int errs = 0, checks = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // ---------------- reference model (behavioural) ----------------
  int   m_phase = 0;          // 0 idle, 1 entering, 2 in self-refresh, 3 leaving
  bit   m_cke = 0, m_stat = 0, m_gnt = 0, m_rfp = 0, m_on = 0, m_runq = 0;
  logic [3:0] m_cmd = 4'b1111;
  logic [1:0] m_sw = 2'b00;
  int   edge_no = 0, rise_edge = -100000;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0; m_cke = 0; m_stat = 0; m_gnt = 0; m_rfp = 0; m_on = 0;
      m_runq = 0; m_cmd = 4'b1111; m_sw = 2'b00; rise_edge = -100000;
    end else begin
      bit nfree, rfree, enter, took_sw, took_rf, wake, old_on;
      logic [3:0] nc;
      edge_no++;
      nfree = (edge_no - rise_edge) > NRD;
      rfree = (edge_no - rise_edge) > RD;
      nc = 4'b1111; enter = 0; took_sw = 0; took_rf = 0; old_on = m_on;
      m_gnt = 0;
      if (m_phase == 0) begin
        wake = 0;
        if (ctrl_en && arm && req) begin
          if (m_cke) begin nc = 4'b0001; enter = 1; end else wake = 1;
        end else if ((m_sw != 0 && nfree) || (m_rfp && nfree) ||
                     (areq && (awr ? nfree : rfree))) begin
          if (!m_cke) wake = 1;
          else if (m_sw != 0) begin nc = (m_sw == 2'b01) ? 4'b0010 : 4'b0001; took_sw = 1; end
          else if (m_rfp) begin nc = 4'b0001; took_rf = 1; end
          else begin nc = awr ? 4'b0100 : 4'b0101; m_gnt = 1; end
        end
        if (enter) m_cke = 0;
        else if (wake || nc != 4'b1111) m_cke = 1;
        else m_cke = keep;
        if (enter) m_sw = 0;
        else if (sw == 2'b01 || sw == 2'b10) m_sw = sw;
        else if (took_sw) m_sw = 0;
        if (enter) m_rfp = 0;
        else if (tick && old_on && nfree) m_rfp = 1;
        else if (took_rf) m_rfp = 0;
        if (enter) m_phase = 1;
      end else if (m_phase == 1) begin
        m_cke = 0; m_stat = 1; m_phase = 2;
      end else if (m_phase == 2) begin
        if (!arm && !req) begin m_cke = 1; m_phase = 3; rise_edge = edge_no; end
      end else begin
        m_stat = 0; m_phase = 0;
      end
      if (enter || !run) m_on = 0;
      else if (run && !m_runq && edge_is_idle(m_phase, enter)) m_on = 1;
      m_runq = run;
      m_cmd = nc;
    end
  end

  // the refresh enable may only start from the idle phase seen before this edge
  bit prev_idle = 1;
  function automatic bit edge_is_idle(int ph, bit ent);
    return prev_idle;
  endfunction
  always @(negedge clk) prev_idle = (m_phase == 0);

  // ---------------- monitor ----------------
  int cyc = 0, rise_cyc = 0, ref_cyc = 0, pall_cyc = 0, self_cyc = 0, gnt_cyc = 0;
  int ref_cnt = 0, gnt_cnt = 0;
  bit pc = 0;

  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [3:0] cv;
      cv = {cs_n, ras_n, cas_n, we_n};
      cyc++;
      chk(cv == m_cmd, "R7 command bus", cv, m_cmd);
      chk(cke == m_cke, "R10 cke", cke, m_cke);
      chk(stat == m_stat, "R3 status", stat, m_stat);
      chk(gnt == m_gnt, "R12 grant", gnt, m_gnt);
      if (cke && !pc) rise_cyc = cyc;
      pc = cke;
      if (cv == 4'b0001 && cke) begin ref_cnt++; ref_cyc = cyc; end
      if (cv == 4'b0001 && !cke) self_cyc = cyc;
      if (cv == 4'b0010) pall_cyc = cyc;
      if (gnt) begin gnt_cnt++; gnt_cyc = cyc; end
    end
  end

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  task automatic wait_gnt(output int lat);
    lat = 0;
    do begin step(); lat++; end while (!gnt && lat < 300);
    areq = 1'b0;
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  endtask

  initial begin
    #(20 * 100000);
    if (!done) begin
      errs++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      finish_run();
    end
  end

  initial begin
    int c0, lat, r0, g0;
    repeat (3) step();
    // R1 reset state
    chk({cs_n, ras_n, cas_n, we_n} == 4'b1111, "R1 bus", {cs_n, ras_n, cas_n, we_n}, 15);
    chk(cke == 0, "R1 cke", cke, 0);
    chk(stat == 0 && gnt == 0, "R1 status/grant", {stat, gnt}, 0);
    rst_n = 1'b1;
    step();
    chk(cke == 0, "R1 cke after release", cke, 0);
    keep = 1'b1; step(); step();
    chk(cke == 1, "R10 leave power-down", cke, 1);

    // R12 write then read with CKE high
    areq = 1; awr = 1; wait_gnt(lat);
    chk(lat == 1, "R12 write latency", lat, 1);
    areq = 1; awr = 0; wait_gnt(lat);
    chk(lat == 1, "R12 read latency", lat, 1);

    // R7 back-to-back software commands
    c0 = cyc; sw = 2'b01; step(); sw = 2'b10; step(); sw = 2'b00; step();
    chk(pall_cyc == c0 + 2, "R7 precharge-all cycle", pall_cyc - c0, 2);
    chk(ref_cyc == c0 + 3, "R7 auto-refresh cycle", ref_cyc - c0, 3);

    // R12 priority: pending software command beats access
    sw = 2'b01; step(); sw = 2'b00; areq = 1; awr = 1; wait_gnt(lat);
    chk(lat == 2, "R12 priority software over access", lat, 2);

    // R8 start periodic refresh
    c0 = cyc; run = 1; step(); tick = 1; step(); tick = 0; step();
    chk(ref_cyc == c0 + 3, "R8 periodic refresh", ref_cyc - c0, 3);

    // R10 / R11 power-down
    keep = 0; step();
    chk(cke == 0, "R10 enter power-down", cke, 0);
    areq = 1; awr = 1; wait_gnt(lat);
    chk(lat == 2, "R11 wake cost", lat, 2);
    step();
    chk(cke == 0, "R11 re-enter power-down", cke, 0);

    // R2 entry from power-down
    c0 = cyc; arm = 1; req = 1; step(); step();
    chk(self_cyc == c0 + 2, "R2 self-refresh command cycle", self_cyc - c0, 2);
    chk(cke == 0, "R2 cke low with command", cke, 0);
    step();
    chk(stat == 1, "R3 status set", stat, 1);
    keep = 1;

    // R9 / R4 inside self-refresh
    g0 = gnt_cnt; r0 = ref_cnt;
    areq = 1; awr = 0; req = 0;
    for (int i = 0; i < 8; i++) begin
      tick = i[0]; sw = i[1] ? 2'b10 : 2'b00; step();
    end
    tick = 0; sw = 0;
    chk(gnt_cnt == g0 && ref_cnt == r0, "R9 stalled in self-refresh", gnt_cnt - g0 + ref_cnt - r0, 0);
    chk(stat == 1 && cke == 0, "R4 one bit cleared keeps self-refresh", {stat, cke}, 2);

    // exit and lockouts
    arm = 0; step();
    chk(cke == 1 && stat == 1, "R3 cke rises before status clears", {cke, stat}, 3);
    step();
    chk(stat == 0, "R3 status cleared", stat, 0);
    sw = 2'b10; step(); sw = 0; tick = 1; step(); tick = 0;
    wait_gnt(lat);
    chk(ref_cyc - rise_cyc == NRD + 1, "R5 non-read lockout", ref_cyc - rise_cyc, NRD + 1);
    chk(gnt_cyc - rise_cyc == RD + 1, "R6 read lockout", gnt_cyc - rise_cyc, RD + 1);

    // R8 stays stopped until re-enabled
    r0 = ref_cnt; tick = 1; step(); tick = 0; repeat (4) step();
    chk(ref_cnt == r0, "R8 refresh stopped after exit", ref_cnt - r0, 0);
    run = 0; step(); run = 1; step(); tick = 1; step(); tick = 0; step(); step();
    chk(ref_cnt == r0 + 1, "R8 refresh re-enabled", ref_cnt - r0, 1);

    // R2 no entry without controller enable
    ctrl_en = 0; arm = 1; req = 1; repeat (4) step();
    chk(stat == 0 && cke == 1, "R2 blocked by controller enable", {stat, cke}, 1);
    ctrl_en = 1; arm = 0; req = 0; repeat (3) step();
    finish_run();
  end
endmodule